// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Fall-Through Selection

This block carries 36-bit words from a write port clocked by `wclk` to a read port clocked by `rclk`. The two clocks may be fully asynchronous. Binary pointers are kept in each domain, and their Gray-coded copies cross over through two-stage synchronizers. Every flag is derived from the count of words held in storage. A word that has already moved into the read-side output register is not part of that count.

The read-side timing mode is chosen at run time. On the first read-clock edge after a full reset, the block samples `mode_sel`:

- **Standard mode** (`mode_sel` high): every word, including the first, needs a qualified read. The read flag acts as a not-empty indication.
- **Fall-through mode** (`mode_sel` low): the oldest stored word moves into the output register without any request. The read flag then means the output holds a fresh word.

The almost-empty threshold and the almost-full threshold come from two offset inputs. There are two reset inputs:

- `rst_n` clears everything, including the latched mode.
- `prst_n` clears the pointers and flags but keeps the latched mode.

Top module: `dcfifo_fwft`

## Requirements
- R1: `mode_sel` is sampled on the first `rclk` rising edge after `rst_n` goes high. A 1 selects standard mode and a 0 selects fall-through mode. A partial reset through `prst_n` leaves the latched mode unchanged.
- R2: In standard mode, `r_data` changes only on a qualified read. A qualified read is an `rclk` edge with `r_cs_n`=0, `r_dir`=1, `r_en`=1, `r_mb`=0 and `r_ef_or`=1. Words come out in the order they were accepted.
- R3: In fall-through mode, a word written to an empty FIFO reaches `r_data`, with `r_ef_or` high, no earlier than the third `rclk` edge after the write edge and with no request. Without a qualified read, the word and the flag hold.
- R4: A read attempted while `r_ef_or` is low is ignored. `r_data` keeps its previous word and no stored word is lost.
- R5: `w_ff_ir` is low exactly when the write side counts DEPTH stored words. A write attempted while it is low is ignored.
- R6: `r_ae` is low while the stored word count is at most `ae_off`, and high above it. In fall-through mode, the word in the output register is not counted.
- R7: `w_af` is low while the stored word count is at least DEPTH minus `af_off`, and high below it.
- R8: While either reset is low, `w_ff_ir`=0, `r_ef_or`=0, `r_ae`=0 and `w_af`=1. After release, `w_ff_ir` is still 0 after the first `wclk` edge and is 1 after the second.
- R9: A word is stored only on a `wclk` edge with `w_cs_n`=0, `w_dir`=1, `w_en`=1, `w_mb`=0 and `w_ff_ir`=1. Any other combination stores nothing.
- R10: The Gray-coded pointers change by at most one bit per edge of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| mode_sel | input | 1 | Timing mode pin: 1 standard, 0 fall-through |
| ae_off | input | AW | Almost-empty offset |
| af_off | input | AW | Almost-full offset |
| w_cs_n | input | 1 | Write port select, active low |
| w_dir | input | 1 | Write port direction, 1 = write |
| w_en | input | 1 | Write enable |
| w_mb | input | 1 | Write side message-path select; 1 blocks FIFO writes |
| w_data | input | W | Write data |
| w_ff_ir | output | 1 | Full (low) / input ready (high), write clock |
| w_af | output | 1 | Almost-full, active low, write clock |
| r_cs_n | input | 1 | Read port select, active low |
| r_dir | input | 1 | Read port direction, 1 = read |
| r_en | input | 1 | Read enable |
| r_mb | input | 1 | Read side message-path select; 1 blocks FIFO reads |
| r_data | output | W | Output register |
| r_ef_or | output | 1 | Empty (low) / output ready (high), read clock |
| r_ae | output | 1 | Almost-empty, active low, read clock |

## Verification
Each result has its own timing relative to the stimulus:

- Write-side flags react on the same `wclk` edge that accepts a write. The bench samples `w_ff_ir` and `w_af` half a write period later.
- Read-side flags see a write only after two `rclk` synchronizer edges. A fall-through load needs a third edge.
- After any stimulus whose result crosses domains, the bench waits several edges of both clocks before it compares flags against its queue model.

The fall-through latency is measured by counting `rclk` edges from the write edge until `r_ef_or` rises. Read data in either mode is compared half a read period after the edge that performed the read. The exit from reset is checked on the first and second `wclk` edges after release.

// File: rtl/dcfifo_fwft.sv
`timescale 1ns/1ps
module dcfifo_fwft #(
  parameter int W     = 36,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  input  logic          w_cs_n,
  input  logic          w_dir,
  input  logic          w_en,
  input  logic          w_mb,
  input  logic [W-1:0]  w_data,
  output logic          w_ff_ir,
  output logic          w_af,
  input  logic          r_cs_n,
  input  logic          r_dir,
  input  logic          r_en,
  input  logic          r_mb,
  output logic [W-1:0]  r_data,
  output logic          r_ef_or,
  output logic          r_ae
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEP = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] mem [DEPTH];
  wire any_rst_n = rst_n & prst_n;

  // write domain
  logic [1:0]    w_rs;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  wire           w_live = w_rs[1];
  wire [PW-1:0]  wcnt   = wbin - g2b(rg_s2);
  wire           w_req  = ~w_cs_n & w_dir & w_en & ~w_mb;
  wire           w_do   = w_req & w_ff_ir;

  assign w_ff_ir = w_live & (wcnt != DEP);
  assign w_af    = ~w_live | (wcnt < (DEP - {1'b0, af_off}));

  always_ff @(posedge wclk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      w_rs  <= '0;
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      w_rs  <= {w_rs[0], 1'b1};
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (w_do) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk)
    if (w_do) mem[wbin[AW-1:0]] <= w_data;

  // read domain
  logic [1:0]    r_rs;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          r_mvld, r_std, r_or_q;
  wire           r_live = r_rs[1];
  wire           r_fwft = r_mvld & ~r_std;
  wire [PW-1:0]  rcnt   = g2b(wg_s2) - rbin;
  wire           r_has  = rcnt != '0;
  wire           r_req  = ~r_cs_n & r_dir & r_en & ~r_mb;
  wire           r_pop  = r_live & r_has & (r_fwft ? (~r_or_q | r_req) : r_req);

  assign r_ef_or = r_live & (r_fwft ? r_or_q : r_has);
  assign r_ae    = r_live & (rcnt > {1'b0, ae_off});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      r_mvld <= 1'b0;
      r_std  <= 1'b1;
    end else if (!r_mvld) begin
      r_mvld <= 1'b1;
      r_std  <= mode_sel;
    end
  end

  always_ff @(posedge rclk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      r_rs   <= '0;
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      r_or_q <= 1'b0;
      r_data <= '0;
    end else begin
      r_rs  <= {r_rs[0], 1'b1};
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (r_pop) begin
        r_data <= mem[rbin[AW-1:0]];
        rbin   <= rbin + 1'b1;
        rgray  <= b2g(rbin + 1'b1);
      end
      if (!r_fwft)     r_or_q <= 1'b0;
      else if (!r_or_q) r_or_q <= r_live & r_has;
      else if (r_req)   r_or_q <= r_has;
    end
  end

  // R8
  reset_flags_chk: assert property (@(posedge wclk) !w_live |-> (!w_ff_ir && w_af));
  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!w_live)
    (w_req && !w_ff_ir) |=> $stable(wbin));
  // R4
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!r_live)
    (!r_fwft && r_req && !r_ef_or) |=> ($stable(r_data) && $stable(rbin)));
  // R3
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!r_live)
    (r_fwft && r_ef_or && !r_req) |=> ($stable(r_data) && r_ef_or));
  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!w_live)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!r_live)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/dcfifo_fwft_tb.sv
`timescale 1ns/1ps
module dcfifo_fwft_tb;
  localparam int W = 36, DEPTH = 256, AW = 8;
  logic wclk = 0, rclk = 0;
  logic rst_n = 0, prst_n = 1, mode_sel = 1;
  logic [AW-1:0] ae_off = 4, af_off = 4;
  logic w_cs_n = 1, w_dir = 0, w_en = 0, w_mb = 0;
  logic [W-1:0] w_data = '0;
  logic r_cs_n = 1, r_dir = 0, r_en = 0, r_mb = 0;
  logic w_ff_ir, w_af, r_ef_or, r_ae;
  logic [W-1:0] r_data;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_fwft #(.W(W), .DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .ae_off(ae_off), .af_off(af_off),
    .w_cs_n(w_cs_n), .w_dir(w_dir), .w_en(w_en), .w_mb(w_mb), .w_data(w_data),
    .w_ff_ir(w_ff_ir), .w_af(w_af),
    .r_cs_n(r_cs_n), .r_dir(r_dir), .r_en(r_en), .r_mb(r_mb),
    .r_data(r_data), .r_ef_or(r_ef_or), .r_ae(r_ae));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit fwft = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last = '0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int memcnt();
    if (fwft && q.size() > 0) return q.size() - 1;
    return q.size();
  endfunction

  task automatic settle();
    repeat (5) @(posedge rclk);
    repeat (5) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic chk_flags(input string tag);
    settle();
    chk(r_ef_or == (q.size() > 0), {tag, " ef_or"}, r_ef_or, q.size() > 0);
    chk(r_ae == (memcnt() > ae_off), {tag, " ae"}, r_ae, memcnt() > ae_off);
    @(negedge wclk);
    chk(w_ff_ir == (memcnt() < DEPTH), {tag, " ff_ir"}, w_ff_ir, memcnt() < DEPTH);
    chk(w_af == (memcnt() < DEPTH - af_off), {tag, " af"}, w_af, memcnt() < DEPTH - af_off);
  endtask

  task automatic do_reset(input bit full, input bit mode, input bit new_fwft);
    @(negedge wclk);
    if (full) rst_n = 0; else prst_n = 0;
    mode_sel = mode;
    repeat (5) @(posedge rclk);
    repeat (5) @(posedge wclk);
    @(negedge wclk);
    // R8
    chk(!w_ff_ir && !r_ef_or && !r_ae && w_af, "R8 flags in reset",
        {w_ff_ir, r_ef_or, r_ae, w_af}, 4'b0001);
    rst_n = 1;
    prst_n = 1;
    @(posedge wclk); #1;
    chk(!w_ff_ir, "R8 ff_ir after 1st edge", w_ff_ir, 0);
    @(posedge wclk); #1;
    chk(w_ff_ir, "R8 ff_ir after 2nd edge", w_ff_ir, 1);
    q.delete();
    last = '0;
    fwft = new_fwft;
    settle();
  endtask

  task automatic wr(input logic [W-1:0] d, input logic cs_n = 0, input logic dir = 1,
                    input logic en = 1, input logic mb = 0);
    @(negedge wclk);
    w_cs_n = cs_n; w_dir = dir; w_en = en; w_mb = mb; w_data = d;
    if (!cs_n && dir && en && !mb && memcnt() < DEPTH) q.push_back(d);
    @(posedge wclk);
    @(negedge wclk);
    w_cs_n = 1; w_dir = 0; w_en = 0; w_mb = 0;
  endtask

  task automatic rd(input string tag, input logic en = 1);
    bit flag_hi;
    logic [W-1:0] exp;
    @(negedge rclk);
    flag_hi = r_ef_or;
    r_cs_n = 0; r_dir = 1; r_en = en; r_mb = 0;
    @(posedge rclk);
    @(negedge rclk);
    r_cs_n = 1; r_dir = 0; r_en = 0;
    exp = last;
    if (en && flag_hi && q.size() > 0) begin
      if (!fwft) exp = q.pop_front();
      else begin
        void'(q.pop_front());
        if (q.size() > 0) exp = q[0];
      end
    end
    last = exp;
    chk(r_data == exp, tag, r_data, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // standard mode
    do_reset(1, 1, 0);
    rd("R4 empty read ignored std");
    // R9: each disqualifying control stores nothing
    wr(36'h111, 1, 1, 1, 0);
    wr(36'h222, 0, 0, 1, 0);
    wr(36'h333, 0, 1, 0, 0);
    wr(36'h444, 0, 1, 1, 1);
    chk_flags("R9 unqualified writes");
    for (int i = 0; i < 3; i++) wr(36'hA00 + i);
    chk_flags("R6 three words");
    chk(r_data == 0, "R1 standard no fall-through", r_data, 0);
    wr(36'hA03);
    wr(36'hA04);
    chk_flags("R6 five words");
    rd("R2 read with enable low", 0);
    for (int i = 0; i < 5; i++) rd("R2 order std");
    chk_flags("R2 drained");
    rd("R4 read after drain ignored");
    // full and almost-full
    for (int i = 0; i < DEPTH; i++) begin
      wr(36'hB0000 + i);
      if (i == DEPTH - 6) chk(w_af, "R7 af high below threshold", w_af, 1);
      if (i == DEPTH - 5) chk(!w_af, "R7 af low at threshold", w_af, 0);
      if (i == DEPTH - 2) chk(w_ff_ir, "R5 ff_ir high at DEPTH-1", w_ff_ir, 1);
    end
    chk(!w_ff_ir, "R5 ff_ir low at DEPTH", w_ff_ir, 0);
    wr(36'hDEAD);
    chk_flags("R5 write while full ignored");
    for (int i = 0; i < DEPTH; i++) rd("R5 order after full");
    chk_flags("R5 drained after full");

    // fall-through mode
    do_reset(1, 0, 1);
    ae_off = 1;
    rd("R4 empty read ignored fwft");
    begin
      int n;
      bit seen;
      n = 0;
      seen = 0;
      @(negedge wclk);
      w_cs_n = 0; w_dir = 1; w_en = 1; w_data = 36'hC00;
      q.push_back(36'hC00);
      @(posedge wclk);
      w_en <= 0;
      for (int k = 0; k < 10 && !seen; k++) begin
        @(posedge rclk);
        n++;
        #0.5;
        seen = r_ef_or;
      end
      w_cs_n = 1; w_dir = 0;
      chk(seen && n >= 3 && n <= 4, "R3 fall-through latency", n, 3);
      chk(r_data == 36'hC00, "R3 fall-through data", r_data, 36'hC00);
      last = 36'hC00;
    end
    chk_flags("R3 held without request");
    chk(r_data == 36'hC00, "R3 data held", r_data, 36'hC00);
    wr(36'hC01);
    chk_flags("R6 output register not counted");
    wr(36'hC02);
    chk_flags("R6 two stored words fwft");
    rd("R3 fwft read advances");
    settle();
    rd("R3 fwft read advances");
    settle();
    rd("R3 fwft last read");
    chk_flags("R4 fwft drained");
    chk(r_data == 36'hC02, "R4 last word stays", r_data, 36'hC02);
    rd("R4 fwft read while not ready");

    // partial reset keeps the fall-through mode even with the pin changed
    do_reset(0, 1, 1);
    wr(36'hE00);
    settle();
    chk(r_data == 36'hE00 && r_ef_or, "R1 mode kept over partial reset", r_data, 36'hE00);
    last = 36'hE00;

    // full reset picks standard mode again
    do_reset(1, 1, 0);
    wr(36'hF00);
    chk_flags("R1 standard after full reset");
    chk(r_data == 0, "R1 standard needs request", r_data, 0);
    rd("R2 standard read");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule